// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers four single-cycle event strobes and turns them into one active-high interrupt line for a host processor. The four events are: a timecode frame received, a timecode transmit buffer loaded, a chosen video line passed, and expiry of a built-in interval timer. Each event sets its own sticky status flag, and each flag has a private enable. The interrupt line is high while at least one flag is set whose enable is also set.

A byte-wide register gives the host a view of all flags and enables. A host read returns the register and clears every flag at once. A host write changes only the enables. A flag is set whether or not its enable is on, so the host can also poll.

The 10-bit interval timer raises the timer event. It counts rising edges of one of three asynchronous tick inputs: a slow base tick, the receive bit clock or the transmit bit clock. Each tick input is first synchronised to the system clock. Each time the timer expires it reloads from a value the host writes.

Top module: `irq_event_hub`

## Requirements
- R1: After synchronous reset, all flags and enables read as zero and `irq_o` is low.
- R2: A strobe on an event input sets its flag, whatever the enables hold. The flags sit in `reg_rdata_o[3:0]`: bit 0 is receive done, bit 1 is transmit loaded, bit 2 is video line and bit 3 is timer expiry.
- R3: `irq_o` is high exactly when some flag bit and the enable at the same index plus 4 are both 1.
- R4: `reg_rdata_o` always presents {enables[3:0], flags[3:0]}. A cycle with `reg_rd_i` high clears all four flags at the next clock edge.
- R5: If an event strobe coincides with a clearing read, that event's flag is set after the read.
- R6: A cycle with `reg_wr_i` high loads the enables from `reg_wdata_i[7:4]`. `reg_wdata_i[3:0]` has no effect on the flags.
- R7: A flag stays set, with no read, until a read clears it.
- R8: After the reload value N is written, the timer flag is set on the (N+1)-th rising edge of the selected tick source and not before. It then reloads N and repeats. N ranges from 0 to 1023.
- R9: `tmr_sel_i` picks the counted source: 0 is `tick_base_i`, 1 is `rx_bitclk_i`, 2 is `tx_bitclk_i`, and 3 stops counting. Edges on the sources that are not selected have no effect.
- R10: Writing a new reload value restarts the count from that value, and any ticks counted before are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rx_done_i | input | 1 | Strobe: timecode frame received |
| ev_tx_loaded_i | input | 1 | Strobe: transmit buffer loaded |
| ev_line_i | input | 1 | Strobe: selected video line passed |
| tick_base_i | input | 1 | Asynchronous slow base tick |
| rx_bitclk_i | input | 1 | Asynchronous receive bit clock |
| tx_bitclk_i | input | 1 | Asynchronous transmit bit clock |
| tmr_sel_i | input | 2 | Timer tick source select |
| tmr_ld_i | input | 1 | Load strobe for the timer reload value |
| tmr_val_i | input | 10 | Timer reload value |
| reg_rd_i | input | 1 | Host read of the register (clears flags) |
| reg_wr_i | input | 1 | Host write of the enables |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Register view {enables, flags} |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The flag and enable logic is swept over all 256 pairs of enable pattern and event pattern. Each pair checks that the interrupt fires only where a flag and its enable overlap, and that a read gives back the pair and then clears only the flags. Dedicated cases hit a strobe that lands with a clearing read, and a write whose low nibble is all ones. These show a lost event or a write that reaches the flags. The timer is run at several reload values, including 0 and 1023, on each of the three sources, with edges on the other sources mixed in. This separates an off-by-one in the count, a wrong source select and a missed restart on reload.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int NUM_EV  = 4;
    localparam int NUM_SRC = 3;

    localparam int EV_RX   = 0;
    localparam int EV_TX   = 1;
    localparam int EV_LINE = 2;
    localparam int EV_TMR  = 3;

    typedef logic [NUM_EV-1:0]  ev_vec_t;
    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_RXCK = 2'd1,
        SEL_TXCK = 2'd2,
        SEL_OFF  = 2'd3
    } tick_sel_e;

    typedef struct packed {
        ev_vec_t en;
        ev_vec_t flag;
    } hub_reg_t;

    function automatic ev_vec_t next_flags(input ev_vec_t cur, input logic clr,
                                           input ev_vec_t ev);
        return (clr ? '0 : cur) | ev;
    endfunction

    function automatic logic pick_tick(input src_vec_t t, input tick_sel_e s);
        case (s)
            SEL_BASE: return t[0];
            SEL_RXCK: return t[1];
            SEL_TXCK: return t[2];
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_tick_sync.sv
module irq_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], raw_i};
            prev  <= chain[LAST];
        end
    end

    assign rise_o = chain[LAST] & ~prev;

endmodule

// File: rtl/irq_interval_timer.sv
module irq_interval_timer
    import irq_hub_pkg::*;
#(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  src_vec_t         rise_i,
    input  tick_sel_e        sel_i,
    input  logic             ld_i,
    input  logic [TMR_W-1:0] val_i,
    output logic             fire_o
);
    logic [TMR_W-1:0] reload_q;
    logic [TMR_W-1:0] cnt_q;
    logic             tick;

    assign tick = pick_tick(rise_i, sel_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            cnt_q    <= '0;
            fire_o   <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (ld_i) begin
                reload_q <= val_i;
                cnt_q    <= val_i;
            end else if (tick) begin
                if (cnt_q == '0) begin
                    fire_o <= 1'b1;
                    cnt_q  <= reload_q;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_hub_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ev_vec_t  ev_i,
    input  logic     rd_i,
    input  logic     wr_i,
    input  ev_vec_t  wr_en_i,
    output hub_reg_t reg_o,
    output logic     irq_o
);
    hub_reg_t reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q.flag <= next_flags(reg_q.flag, rd_i, ev_i);
            if (wr_i) begin
                reg_q.en <= wr_en_i;
            end
        end
    end

    assign reg_o = reg_q;
    assign irq_o = |(reg_q.flag & reg_q.en);

endmodule

// File: rtl/irq_event_hub.sv
module irq_event_hub
    import irq_hub_pkg::*;
#(
    parameter int TMR_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_rx_done_i,
    input  logic             ev_tx_loaded_i,
    input  logic             ev_line_i,
    input  logic             tick_base_i,
    input  logic             rx_bitclk_i,
    input  logic             tx_bitclk_i,
    input  logic [1:0]       tmr_sel_i,
    input  logic             tmr_ld_i,
    input  logic [TMR_W-1:0] tmr_val_i,
    input  logic             reg_rd_i,
    input  logic             reg_wr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    output logic             irq_o
);
    src_vec_t raw_src;
    src_vec_t rise;
    logic     tmr_fire;
    ev_vec_t  ev_all;
    hub_reg_t view;

    assign raw_src = {tx_bitclk_i, rx_bitclk_i, tick_base_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        irq_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_src[g]),
            .rise_o (rise[g])
        );
    end

    irq_interval_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise),
        .sel_i  (tick_sel_e'(tmr_sel_i)),
        .ld_i   (tmr_ld_i),
        .val_i  (tmr_val_i),
        .fire_o (tmr_fire)
    );

    always_comb begin
        ev_all          = '0;
        ev_all[EV_RX]   = ev_rx_done_i;
        ev_all[EV_TX]   = ev_tx_loaded_i;
        ev_all[EV_LINE] = ev_line_i;
        ev_all[EV_TMR]  = tmr_fire;
    end

    irq_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev_all),
        .rd_i    (reg_rd_i),
        .wr_i    (reg_wr_i),
        .wr_en_i (reg_wdata_i[7:4]),
        .reg_o   (view),
        .irq_o   (irq_o)
    );

    assign reg_rdata_o = view;

endmodule

// File: rtl/irq_event_hub_chk.sv
module irq_event_hub_chk (
    input logic       clk,
    input logic       rst,
    input logic       ev_rx_done_i,
    input logic       ev_line_i,
    input logic       reg_rd_i,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       irq_o
);
    p_set_rx_r2: assert property (@(posedge clk) disable iff (rst)
        ev_rx_done_i |=> reg_rdata_o[0]);

    p_set_line_r2: assert property (@(posedge clk) disable iff (rst)
        ev_line_i |=> reg_rdata_o[2]);

    p_irq_match_r3: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(reg_rdata_o[3:0] & reg_rdata_o[7:4]));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && !ev_rx_done_i) |=> !reg_rdata_o[0]);

    p_no_loss_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && ev_line_i) |=> reg_rdata_o[2]);

    p_write_en_r6: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> reg_rdata_o[7:4] == $past(reg_wdata_i[7:4]));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[1] && !reg_rd_i) |=> reg_rdata_o[1]);

endmodule

bind irq_event_hub irq_event_hub_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_rx_done_i (ev_rx_done_i),
    .ev_line_i    (ev_line_i),
    .reg_rd_i     (reg_rd_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .irq_o        (irq_o)
);

// File: tb/irq_event_hub_bench.sv
module irq_event_hub_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_rx = 1'b0, ev_tx = 1'b0, ev_line = 1'b0;
    logic [2:0] src = 3'b000;
    logic [1:0] sel = 2'd0;
    logic       ld = 1'b0;
    logic [9:0] val = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_event_hub u_irq_event_hub (
        .clk            (clk),
        .rst            (rst),
        .ev_rx_done_i   (ev_rx),
        .ev_tx_loaded_i (ev_tx),
        .ev_line_i      (ev_line),
        .tick_base_i    (src[0]),
        .rx_bitclk_i    (src[1]),
        .tx_bitclk_i    (src[2]),
        .tmr_sel_i      (sel),
        .tmr_ld_i       (ld),
        .tmr_val_i      (val),
        .reg_rd_i       (rd),
        .reg_wr_i       (wr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .irq_o          (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic host_rd(output logic [7:0] v);
        @(negedge clk); rd = 1'b1; #1 v = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic host_wr(input logic [7:0] d);
        @(negedge clk); wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic peek(output logic [7:0] v, output logic q);
        @(negedge clk); #1 v = rdata; q = irq;
    endtask

    task automatic strobe(input logic [2:0] m);
        @(negedge clk); {ev_line, ev_tx, ev_rx} = m;
        @(negedge clk); {ev_line, ev_tx, ev_rx} = 3'b000;
    endtask

    task automatic pulse_src(input int idx);
        @(negedge clk); src[idx] = 1'b1;
        repeat (3) @(negedge clk);
        src[idx] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_reload(input logic [9:0] n);
        @(negedge clk); ld = 1'b1; val = n;
        @(negedge clk); ld = 1'b0;
    endtask

    task automatic timer_case(input int s, input int n, input bit noise);
        logic [7:0] v; logic q;
        sel = 2'(s);
        load_reload(10'(n));
        host_rd(v);
        for (int k = 0; k < n; k++) begin
            pulse_src(s);
            if (noise) begin
                pulse_src((s + 1) % 3);
                pulse_src((s + 2) % 3);
            end
        end
        pulse_src((s + 1) % 3);
        pulse_src((s + 2) % 3);
        peek(v, q);
        check($sformatf("R8/R9 early sel=%0d n=%0d", s, n), v[3], 0);
        pulse_src(s);
        peek(v, q);
        check($sformatf("R8 fire sel=%0d n=%0d", s, n), v[3], 1);
        host_rd(v);
        for (int k = 0; k < n; k++) pulse_src(s);
        peek(v, q);
        check($sformatf("R8 repeat early sel=%0d n=%0d", s, n), v[3], 0);
        pulse_src(s);
        peek(v, q);
        check($sformatf("R8 repeat fire sel=%0d n=%0d", s, n), v[3], 1);
        host_rd(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v; logic q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        peek(v, q);
        check("R1 reset view", v, 0);
        check("R1 reset irq", q, 0);

        sel = 2'd0;
        load_reload(10'd0);
        for (int e = 0; e < 16; e++) begin
            for (int s = 0; s < 16; s++) begin
                host_rd(v);
                host_wr({4'(e), 4'hF});
                if (s[3]) pulse_src(0);
                strobe(3'(s));
                peek(v, q);
                check($sformatf("R2/R6 view e=%0d s=%0d", e, s), v, (e << 4) | s);
                check($sformatf("R3 irq e=%0d s=%0d", e, s), q, int'((e & s) != 0));
                host_rd(v);
                check($sformatf("R4 read e=%0d s=%0d", e, s), v, (e << 4) | s);
                peek(v, q);
                check($sformatf("R4 cleared e=%0d s=%0d", e, s), v, e << 4);
            end
        end

        host_wr(8'hF0);
        strobe(3'b100);
        @(negedge clk); rd = 1'b1; ev_rx = 1'b1;
        @(negedge clk); rd = 1'b0; ev_rx = 1'b0;
        peek(v, q);
        check("R5 event with read", v[3:0], 1);
        check("R5 irq kept", q, 1);
        host_rd(v);

        host_wr(8'h0F);
        peek(v, q);
        check("R6 low nibble ignored", v, 0);

        strobe(3'b010);
        repeat (20) @(negedge clk);
        peek(v, q);
        check("R7 sticky", v[3:0], 2);
        host_rd(v);

        timer_case(0, 0, 1'b1);
        timer_case(1, 3, 1'b1);
        timer_case(2, 5, 1'b1);
        timer_case(1, 1, 1'b0);
        timer_case(0, 1023, 1'b0);

        sel = 2'd3;
        load_reload(10'd0);
        host_rd(v);
        for (int k = 0; k < 3; k++) begin
            pulse_src(0); pulse_src(1); pulse_src(2);
        end
        peek(v, q);
        check("R9 sel off", v[3], 0);

        sel = 2'd2;
        load_reload(10'd4);
        host_rd(v);
        pulse_src(2); pulse_src(2);
        load_reload(10'd2);
        pulse_src(2); pulse_src(2);
        peek(v, q);
        check("R10 restart early", v[3], 0);
        pulse_src(2);
        peek(v, q);
        check("R10 restart fire", v[3], 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule